// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block recovers characters from an asynchronous serial line. A free-running enable pulse, supplied from outside at sixteen times the bit rate, paces the sampling. A falling edge on the idle-high line starts a character. Each bit is decided by a three-sample majority vote near its centre. The block collects 8 or 9 data bits, least significant first, then an optional even-parity bit, then one stop bit. The finished character and its error flags go into holding registers, which a host reads through plain strobes.

A character whose start, data, parity and stop samples all read low is taken as a break. A break is stored like a finished character, with the framing-error and receiver-full flags set. It also forces the stored byte and the stored ninth bit to zero and raises its own break flag. After any character whose stop sample reads low, the receiver ignores the line until the line has been seen high again, so a held break does not restart reception.

The host clears receiver-full, overrun, noise, framing and parity flags with a two-step sequence: a status read while a character or an overrun is pending, followed by a data read. The break flag clears on a status read made while the line is high. The data path is a holding register, not a stream. Its only back-pressure is the overrun rule: a character that completes while receiver-full is still set is dropped.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset, rx_data is 0x00, and rx_bit9, rx_full, rx_ovr, rx_noise, rx_ferr, rx_perr, rx_brk and rx_busy are all 0.
- R2: With nine_bit=0, eight data bits received least significant bit first appear on rx_data[7:0] and rx_full rises, with rx_bit9=0.
- R3: With nine_bit=1, nine data bits are received and the ninth one (the last data bit on the line) appears on rx_bit9.
- R4: With par_en=1, one parity bit follows the data. Parity is even: the data bits and the parity bit together hold an even number of ones. A mismatch sets rx_perr. With par_en=0, no parity bit is expected and rx_perr stays 0.
- R5: A stop bit whose vote is 0 sets rx_ferr together with rx_full.
- R6: Each bit is the majority of the 7th, 8th and 9th of its sixteen samples. If those three samples disagree in any bit of a character, rx_noise is set, and the voted data is still correct.
- R7: If the start bit votes high (a low pulse shorter than half a bit), reception is abandoned and no flag changes.
- R8: A break sets rx_full, rx_ferr and rx_brk and forces rx_data to 0x00 and rx_bit9 to 0, even if they held other values.
- R9: A character that completes while rx_full is 1 sets rx_ovr. Its data and flags are discarded, and rx_data and rx_bit9 keep their earlier values.
- R10: A pulse of rd_status while rx_full or rx_ovr is 1, followed later by a pulse of rd_data, clears rx_full, rx_ovr, rx_noise, rx_ferr and rx_perr. A pulse of rd_data with no such status read before it has no effect.
- R11: rx_brk clears on a rd_status pulse only if the line is high at that moment. A status read while the line is still low leaves rx_brk set.
- R12: rx_busy is 1 from start detection until the stop-bit vote. After a character whose stop vote is 0, no new start is detected until the line has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| nine_bit | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | 1 = an even-parity bit follows the data |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth data bit |
| rx_full | output | 1 | Character waiting |
| rx_ovr | output | 1 | Overrun |
| rx_noise | output | 1 | Vote disagreement seen |
| rx_ferr | output | 1 | Stop bit read low |
| rx_perr | output | 1 | Parity mismatch |
| rx_brk | output | 1 | Break received |
| rx_busy | output | 1 | Reception in progress |

## Verification
The bench builds the block with sixteen samples per bit and the vote centred on the 8th sample, and it pulses tick every fourth clock. With this setting, a single glitch lasting one tick period can be placed inside the vote window, and a false start lasting three ticks falls clearly short of it. Each bit lasts 64 clocks, so a full character with parity and stop stays short enough for overrun, held-break and re-arm sequences to run one after another.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic [8:0] data;
    logic       ferr;
    logic       perr;
    logic       noise;
    logic       brk;
  } rx_char_t;
endpackage

// File: rtl/sr_vote.sv
module sr_vote (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic bit_o,
  output logic noisy
);
  always_comb begin
    bit_o = (a & b) | (a & c) | (b & c);
    noisy = (a ^ b) | (b ^ c);
  end
endmodule

// File: rtl/sr_framer.sv
module sr_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int VOTE_C = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     nine_bit,
  input  logic     par_en,
  output logic     busy,
  output logic     done,
  output rx_char_t ch
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] S_A   = CW'(VOTE_C - 2);
  localparam logic [CW-1:0] S_B   = CW'(VOTE_C - 1);
  localparam logic [CW-1:0] S_C   = CW'(VOTE_C);
  localparam logic [CW-1:0] S_END = CW'(OVS - 1);

  rx_state_t     state;
  logic [CW-1:0] samp;
  logic [3:0]    bidx;
  logic          s_a, s_b;
  logic [8:0]    shreg;
  logic          par_bit;
  logic          noise_acc;
  logic          allzero;
  logic          armed;
  logic          vbit, vnoise;
  logic [3:0]    last_idx;
  logic [8:0]    word;

  sr_vote u_vote (
    .a    (s_a),
    .b    (s_b),
    .c    (rxd_s),
    .bit_o(vbit),
    .noisy(vnoise)
  );

  always_comb begin
    last_idx = nine_bit ? 4'd8 : 4'd7;
    word     = nine_bit ? shreg : {1'b0, shreg[8:1]};
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      samp      <= '0;
      bidx      <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      shreg     <= '0;
      par_bit   <= 1'b0;
      noise_acc <= 1'b0;
      allzero   <= 1'b0;
      armed     <= 1'b0;
      done      <= 1'b0;
      ch        <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (rxd_s) begin
            armed <= 1'b1;
          end else if (armed) begin
            state     <= ST_START;
            samp      <= '0;
            bidx      <= '0;
            noise_acc <= 1'b0;
            allzero   <= 1'b1;
            armed     <= 1'b0;
          end
        end else begin
          samp <= (samp == S_END) ? '0 : samp + 1'b1;
          if (samp == S_A) s_a <= rxd_s;
          if (samp == S_B) s_b <= rxd_s;
          if (samp == S_C) begin
            noise_acc <= noise_acc | vnoise;
            if (vbit) allzero <= 1'b0;
            case (state)
              ST_START: if (vbit) state <= ST_IDLE;
              ST_DATA:  shreg <= {vbit, shreg[8:1]};
              ST_PAR:   par_bit <= vbit;
              ST_STOP: begin
                done     <= 1'b1;
                state    <= ST_IDLE;
                ch.data  <= word;
                ch.ferr  <= ~vbit;
                ch.perr  <= par_en & (par_bit != ^word);
                ch.noise <= noise_acc | vnoise;
                ch.brk   <= allzero & ~vbit;
              end
              default: ;
            endcase
          end
          if (samp == S_END) begin
            case (state)
              ST_START: state <= ST_DATA;
              ST_DATA: begin
                if (bidx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                bidx <= bidx + 4'd1;
              end
              ST_PAR:  state <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick)); // R12
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_BRK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ch.brk) |-> (ch.ferr && ch.data == 9'd0)); // R8
endmodule

// File: rtl/sr_status.sv
module sr_status
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_char_t   ch,
  input  logic       rd_status,
  input  logic       rd_data,
  input  logic       line_hi,
  output logic [7:0] data,
  output logic       bit9,
  output logic       full,
  output logic       ovr,
  output logic       noise,
  output logic       ferr,
  output logic       perr,
  output logic       brk
);
  logic clr_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data      <= '0;
      bit9      <= 1'b0;
      full      <= 1'b0;
      ovr       <= 1'b0;
      noise     <= 1'b0;
      ferr      <= 1'b0;
      perr      <= 1'b0;
      clr_armed <= 1'b0;
    end else begin
      if (done) begin
        if (full) begin
          ovr <= 1'b1;
        end else begin
          full  <= 1'b1;
          data  <= ch.brk ? 8'h00 : ch.data[7:0];
          bit9  <= ch.brk ? 1'b0 : ch.data[8];
          noise <= ch.noise;
          ferr  <= ch.ferr;
          perr  <= ch.perr;
        end
      end else if (rd_data && clr_armed) begin
        full  <= 1'b0;
        ovr   <= 1'b0;
        noise <= 1'b0;
        ferr  <= 1'b0;
        perr  <= 1'b0;
      end
      if (rd_status && (full || ovr)) clr_armed <= 1'b1;
      else if (rd_data) clr_armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk <= 1'b0;
    end else if (done && ch.brk && !full) begin
      brk <= 1'b1;
    end else if (rd_status && line_hi) begin
      brk <= 1'b0;
    end
  end

  AST_OVR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full) |=> (ovr && $stable(data) && $stable(bit9))); // R9
  AST_BRK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && ch.brk) |=> (full && ferr && brk && data == 8'h00 && !bit9)); // R8
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(rd_data)); // R10
  AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> ($past(rd_status) && $past(line_hi))); // R11
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int VOTE_C = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick,
  input  logic       nine_bit,
  input  logic       par_en,
  input  logic       rd_status,
  input  logic       rd_data,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_full,
  output logic       rx_ovr,
  output logic       rx_noise,
  output logic       rx_ferr,
  output logic       rx_perr,
  output logic       rx_brk,
  output logic       rx_busy
);
  logic [1:0] sync_q;
  logic       rxd_s;
  logic       done;
  rx_char_t   ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxd_s = sync_q[1];

  sr_framer #(.OVS(OVS), .VOTE_C(VOTE_C)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rxd_s   (rxd_s),
    .nine_bit(nine_bit),
    .par_en  (par_en),
    .busy    (rx_busy),
    .done    (done),
    .ch      (ch)
  );

  sr_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .ch       (ch),
    .rd_status(rd_status),
    .rd_data  (rd_data),
    .line_hi  (rxd_s),
    .data     (rx_data),
    .bit9     (rx_bit9),
    .full     (rx_full),
    .ovr      (rx_ovr),
    .noise    (rx_noise),
    .ferr     (rx_ferr),
    .perr     (rx_perr),
    .brk      (rx_brk)
  );
endmodule

// File: tb/serial_rx_brk_test.sv
module serial_rx_brk_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick = 1'b0;
  logic nine_bit = 1'b0;
  logic par_en = 1'b0;
  logic rd_status = 1'b0;
  logic rd_data = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_full, rx_ovr, rx_noise, rx_ferr, rx_perr, rx_brk, rx_busy;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [1:0] tcnt = 2'd0;

  serial_rx_brk uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .nine_bit(nine_bit),
    .par_en(par_en), .rd_status(rd_status), .rd_data(rd_data),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full), .rx_ovr(rx_ovr),
    .rx_noise(rx_noise), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_brk(rx_brk),
    .rx_busy(rx_busy)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
  end

  // {nine, par_en, bad_par, bad_stop, payload[8:0]}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 9'h0A5},
    {4'b0100, 9'h03C},
    {4'b0110, 9'h081},
    {4'b1000, 9'h1C3},
    {4'b1100, 9'h155},
    {4'b0001, 9'h07E}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    for (int i = 0; i < 16; i++) begin
      rxd = (glitch && i == 7) ? ~v : v;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_frame(input bit nine, input bit pen, input logic [8:0] d,
                            input bit bad_par, input bit bad_stop,
                            input bit glitch, input bit look_busy);
    int n;
    logic p;
    n = nine ? 9 : 8;
    p = 1'b0;
    send_bit(1'b0, 1'b0);
    if (look_busy) chk("R12 busy during frame", int'(rx_busy), 1);
    for (int i = 0; i < n; i++) begin
      send_bit(d[i], glitch && i == 0);
      p = p ^ d[i];
    end
    if (pen) send_bit(p ^ bad_par, 1'b0);
    send_bit(~bad_stop, 1'b0);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
  endtask

  task automatic pulse_status();
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_seq();
    pulse_status();
    pulse_data();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 data", int'(rx_data), 0);
    chk("R1 flags", int'({rx_bit9, rx_full, rx_ovr, rx_noise, rx_ferr, rx_perr, rx_brk, rx_busy}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // vector table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      e = VEC[v];
      nine_bit = e[12];
      par_en = e[11];
      @(negedge clk);
      send_frame(e[12], e[11], e[8:0], e[10], e[9], 1'b0, v == 0);
      chk("R2 full", int'(rx_full), 1);
      chk("R2 data", int'(rx_data), int'(e[7:0]));
      chk("R3 bit9", int'(rx_bit9), e[12] ? int'(e[8]) : 0);
      chk("R4 perr", int'(rx_perr), int'(e[11] & e[10]));
      chk("R5 ferr", int'(rx_ferr), int'(e[9]));
      chk("R12 busy idle", int'(rx_busy), 0);
      chk("R8 no brk", int'(rx_brk), 0);
      clear_seq();
      chk("R10 cleared", int'({rx_full, rx_ferr, rx_perr}), 0);
    end

    // R10: data read alone has no effect
    nine_bit = 1'b0; par_en = 1'b0;
    send_frame(1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_data();
    chk("R10 data read alone", int'(rx_full), 1);
    clear_seq();
    chk("R10 seq clears", int'(rx_full), 0);

    // R9 overrun
    send_frame(1'b0, 1'b0, 9'h011, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(1'b0, 1'b0, 9'h0EE, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 ovr", int'(rx_ovr), 1);
    chk("R9 data kept", int'(rx_data), 8'h11);
    clear_seq();
    chk("R10 ovr cleared", int'({rx_ovr, rx_full}), 0);

    // R6 noise
    send_frame(1'b0, 1'b0, 9'h0C7, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 noise", int'(rx_noise), 1);
    chk("R6 data", int'(rx_data), 8'hC7);
    clear_seq();
    chk("R10 noise cleared", int'(rx_noise), 0);

    // R7 false start
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R7 no char", int'(rx_full), 0);
    chk("R7 idle", int'({rx_busy, rx_ferr, rx_noise}), 0);

    // R8 break after a 9-bit char with nonzero data
    nine_bit = 1'b1; par_en = 1'b1;
    send_frame(1'b1, 1'b1, 9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0);
    clear_seq();
    chk("R8 pre data", int'(rx_data), 8'hFF);
    chk("R8 pre bit9", int'(rx_bit9), 1);
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1'b0);
    repeat (128) @(negedge clk);
    chk("R8 full", int'(rx_full), 1);
    chk("R8 ferr", int'(rx_ferr), 1);
    chk("R8 brk", int'(rx_brk), 1);
    chk("R8 data zero", int'(rx_data), 0);
    chk("R8 bit9 zero", int'(rx_bit9), 0);
    chk("R12 no restart while low", int'(rx_busy), 0);
    pulse_status();
    chk("R11 brk held low", int'(rx_brk), 1);
    pulse_data();
    chk("R10 full cleared", int'(rx_full), 0);
    rxd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11 brk before read", int'(rx_brk), 1);
    pulse_status();
    chk("R11 brk cleared", int'(rx_brk), 0);

    // R12 re-arm after line high
    send_frame(1'b1, 1'b1, 9'h0A3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 rearm data", int'(rx_data), 8'hA3);
    chk("R12 rearm full", int'(rx_full), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule